// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries from a page table in memory. The upper ten address bits pick an entry in a first-level directory. That entry gives the base of a second-level table. The next ten bits pick the leaf entry in that table. The lowest twelve bits pass through unchanged as the offset within a 4 KB page. The leaf entry carries the physical page number, a residency flag and the permission flags. The walker checks these flags against the kind of access, either a load or a store.

When the access is allowed, the walker returns the physical address. It also keeps the leaf's usage flags up to date with a read-modify-write: every access sets the referenced flag, and a store also sets the dirty flag. The write is skipped when nothing would change. When the access is refused, the walker returns a fault and no address. Software then services the fault. The walker serves one request at a time. It starts each walk from a root base register that software loads through a dedicated strobe.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req is 0.
- R2: The first read goes to root_base + 4*va[31:22], where root_base is the loaded page number shifted left by 12. The second read goes to (dir_entry[31:12] << 12) + 4*va[21:12].
- R3: A directory entry is present when its bit 0 is 1. If bit 0 is 0, the walk ends with resp_fault=1 after exactly one memory read, and no leaf read or write is made.
- R4: Leaf bit 0 is resident, bit 1 is readable and bit 2 is writable. The walk faults, with no memory write, in three cases: the page is not resident, a load hits a page that is not readable, or a store hits a page that is not writable.
- R5: On success, resp_fault is 0 and resp_paddr = {leaf[31:12], va[11:0]}. On a fault, resp_paddr is 0.
- R6: On success, the leaf write-back has bit 3 (referenced) set. All other bits keep their read value, apart from the dirty bit as R7 describes.
- R7: A successful store also sets bit 4 (dirty) in the write-back. A load leaves the dirty bit as it was.
- R8: The leaf is written back only when the referenced bit or the dirty bit actually changes. Otherwise the walk makes exactly two reads and no write.
- R9: req_ready is 0 from the cycle after acceptance until the walk returns to idle. resp_valid is a single-cycle pulse, and req_ready is 1 again in the following cycle.
- R10: While mem_req is 1 and mem_ack has not yet come, mem_addr, mem_we and mem_wdata stay unchanged.
- R11: A pulse on base_wr_en loads base_wr_ppn as the root page number. Later walks use the new root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Load strobe for the root page number |
| base_wr_ppn | input | 20 | New root directory page number |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle; the request is taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| resp_valid | output | 1 | Single-cycle result strobe |
| resp_fault | output | 1 | Access refused |
| resp_paddr | output | 32 | Translated physical address |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write entry, 0 = read entry |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory completion; mem_rdata is valid in the same cycle |
| mem_rdata | input | 32 | Entry value read |

## Verification
The assertions assume that memory raises mem_ack only while mem_req is high, and for a single cycle per access. They also assume that the requester samples the response only in the cycle resp_valid is high. The bench memory model enforces this: it acknowledges on the falling edge after a programmable wait, then always drops the acknowledge on the next falling edge before it considers a new access. The bench raises requests only when req_ready is high. It writes the root base only between walks. It also runs the same walks at several memory latencies, so that the hold rule is exercised with long waits as well as with zero wait.

// File: rtl/pgwalk_pkg.sv
// Shared definitions for the page table walker: walk states and the
// bit positions of the flags in directory and leaf entries.
package pgwalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_READ = 3'd1,
        ST_L2_READ = 3'd2,
        ST_UPDATE  = 3'd3,
        ST_DONE    = 3'd4
    } walk_state_t;

    // Directory entry flag
    localparam int DIR_PRESENT_BIT = 0;

    // Leaf entry flags
    localparam int LEAF_RES_BIT   = 0;
    localparam int LEAF_RD_BIT    = 1;
    localparam int LEAF_WR_BIT    = 2;
    localparam int LEAF_REF_BIT   = 3;
    localparam int LEAF_DIRTY_BIT = 4;

endpackage

// File: rtl/pgwalk_addr_gen.sv
// Entry address generator.
// For each level of the table it forms the byte address of the entry.
// The formula is table base (a page number shifted by the page offset
// width) plus the index slice of the virtual page number scaled by the
// entry size. Level 0 uses the root page number; deeper levels use the
// page number taken from the previous level's entry.
// Assumes entries are ADDR_W bits wide and tables are page aligned.
module pgwalk_addr_gen #(
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 2
) (
    input  logic [LEVELS*IDX_W-1:0]                   vpn,
    input  logic [LEVELS*IDX_W-1:0]                   root_ppn,
    input  logic [LEVELS*IDX_W-1:0]                   next_ppn,
    output logic [LEVELS-1:0][LEVELS*IDX_W+OFF_W-1:0] lvl_addr
);
    localparam int ADDR_W = LEVELS * IDX_W + OFF_W;
    localparam int ENT_SH = $clog2(ADDR_W / 8);

    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
        localparam int LSB = (LEVELS - 1 - lvl) * IDX_W;
        logic [LEVELS*IDX_W-1:0] tbl_ppn;
        logic [ADDR_W-1:0]       idx_off;

        // Pick the table base for this level
        if (lvl == 0) begin : g_root
            assign tbl_ppn = root_ppn;
        end else begin : g_next
            assign tbl_ppn = next_ppn;
        end

        // Scale the index by the entry size and add it to the table base
        always_comb begin
            idx_off       = ADDR_W'(vpn[LSB +: IDX_W]) << ENT_SH;
            lvl_addr[lvl] = {tbl_ppn, {OFF_W{1'b0}}} + idx_off;
        end
    end

endmodule

// File: rtl/pgwalk_leaf_eval.sv
// Leaf entry evaluation.
// From a raw leaf entry and the access type, this module decides three
// things: whether the access faults, whether the usage flags need a
// write-back, and what the updated entry value is.
// Purely combinational; the result is meaningful only while the leaf
// read completes.
module pgwalk_leaf_eval
    import pgwalk_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] leaf,
    input  logic             is_store,
    output logic             fault,
    output logic             need_wb,
    output logic [ENT_W-1:0] new_leaf
);
    logic can_access;

    // Permission check against the access type, gated by residency
    always_comb begin
        can_access = is_store ? leaf[LEAF_WR_BIT] : leaf[LEAF_RD_BIT];
        fault      = !leaf[LEAF_RES_BIT] || !can_access;
    end

    // Updated usage flags, and whether any of them changed
    always_comb begin
        new_leaf                 = leaf;
        new_leaf[LEAF_REF_BIT]   = 1'b1;
        new_leaf[LEAF_DIRTY_BIT] = leaf[LEAF_DIRTY_BIT] | is_store;
        need_wb                  = (new_leaf != leaf);
    end

endmodule

// File: rtl/pgwalk_fsm.sv
// Walk sequencer.
// Takes one request in idle and then runs the sequence: directory read,
// leaf read, optional leaf write-back, one-cycle response. Each memory
// access is held until it is acknowledged. The walk context (virtual
// address, access type, second-level base, write-back value, result)
// is kept in registers.
// Assumes mem_ack is high only while mem_req is high, and that
// mem_rdata is valid in the cycle of mem_ack.
module pgwalk_fsm
    import pgwalk_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [2*IDX_W+OFF_W-1:0]    req_vaddr,
    input  logic                        req_store,
    input  logic                        mem_ack,
    input  logic [2*IDX_W+OFF_W-1:0]    mem_rdata,
    input  logic [2*IDX_W+OFF_W-1:0]    dir_addr,
    input  logic [2*IDX_W+OFF_W-1:0]    leaf_addr,
    input  logic                        leaf_fault,
    input  logic                        leaf_need_wb,
    input  logic [2*IDX_W+OFF_W-1:0]    leaf_new,
    output logic [2*IDX_W+OFF_W-1:0]    va_q,
    output logic                        store_q,
    output logic [2*IDX_W-1:0]          next_ppn_q,
    output logic                        req_ready,
    output logic                        resp_valid,
    output logic                        resp_fault,
    output logic [2*IDX_W+OFF_W-1:0]    resp_paddr,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [2*IDX_W+OFF_W-1:0]    mem_addr,
    output logic [2*IDX_W+OFF_W-1:0]    mem_wdata
);
    localparam int ADDR_W = 2 * IDX_W + OFF_W;

    walk_state_t       state;
    logic              fault_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [ADDR_W-1:0] wb_q;

    // Walk state and context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            va_q       <= '0;
            store_q    <= 1'b0;
            next_ppn_q <= '0;
            fault_q    <= 1'b0;
            paddr_q    <= '0;
            wb_q       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        store_q <= req_store;
                        fault_q <= 1'b0;
                        paddr_q <= '0;
                        state   <= ST_L1_READ;
                    end
                end
                ST_L1_READ: begin
                    if (mem_ack) begin
                        if (mem_rdata[DIR_PRESENT_BIT]) begin
                            next_ppn_q <= mem_rdata[ADDR_W-1:OFF_W];
                            state      <= ST_L2_READ;
                        end else begin
                            fault_q <= 1'b1;
                            state   <= ST_DONE;
                        end
                    end
                end
                ST_L2_READ: begin
                    if (mem_ack) begin
                        if (leaf_fault) begin
                            fault_q <= 1'b1;
                            state   <= ST_DONE;
                        end else begin
                            paddr_q <= {mem_rdata[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
                            wb_q    <= leaf_new;
                            state   <= leaf_need_wb ? ST_UPDATE : ST_DONE;
                        end
                    end
                end
                ST_UPDATE: begin
                    if (mem_ack) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Handshake and memory port outputs decoded from the state
    always_comb begin
        req_ready  = (state == ST_IDLE);
        resp_valid = (state == ST_DONE);
        resp_fault = fault_q;
        resp_paddr = paddr_q;
        mem_req    = (state == ST_L1_READ) || (state == ST_L2_READ) ||
                     (state == ST_UPDATE);
        mem_we     = (state == ST_UPDATE);
        mem_addr   = (state == ST_L1_READ) ? dir_addr : leaf_addr;
        mem_wdata  = (state == ST_UPDATE) ? wb_q : '0;
    end

endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker, top level.
// Holds the root page number register and connects the sequencer, the
// entry address generator and the leaf evaluator. Entries are one
// address-width word each; tables are page aligned.
// Assumes the root is written only while no walk is in progress.
module pgwalk_top #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     base_wr_en,
    input  logic [2*IDX_W-1:0]       base_wr_ppn,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [2*IDX_W+OFF_W-1:0] req_vaddr,
    input  logic                     req_store,
    output logic                     resp_valid,
    output logic                     resp_fault,
    output logic [2*IDX_W+OFF_W-1:0] resp_paddr,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [2*IDX_W+OFF_W-1:0] mem_addr,
    output logic [2*IDX_W+OFF_W-1:0] mem_wdata,
    input  logic                     mem_ack,
    input  logic [2*IDX_W+OFF_W-1:0] mem_rdata
);
    localparam int LEVELS = 2;
    localparam int PPN_W  = LEVELS * IDX_W;
    localparam int ADDR_W = PPN_W + OFF_W;

    logic [PPN_W-1:0]             root_ppn;
    logic [ADDR_W-1:0]            va_q;
    logic                         store_q;
    logic [PPN_W-1:0]             next_ppn_q;
    logic [LEVELS-1:0][ADDR_W-1:0] lvl_addr;
    logic                         leaf_fault;
    logic                         leaf_need_wb;
    logic [ADDR_W-1:0]            leaf_new;

    // Root directory page number register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_ppn <= '0;
        end else if (base_wr_en) begin
            root_ppn <= base_wr_ppn;
        end
    end

    pgwalk_addr_gen #(
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .LEVELS (LEVELS)
    ) u_addr (
        .vpn      (va_q[ADDR_W-1:OFF_W]),
        .root_ppn (root_ppn),
        .next_ppn (next_ppn_q),
        .lvl_addr (lvl_addr)
    );

    pgwalk_leaf_eval #(
        .ENT_W (ADDR_W)
    ) u_leaf (
        .leaf     (mem_rdata),
        .is_store (store_q),
        .fault    (leaf_fault),
        .need_wb  (leaf_need_wb),
        .new_leaf (leaf_new)
    );

    pgwalk_fsm #(
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_store    (req_store),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .dir_addr     (lvl_addr[0]),
        .leaf_addr    (lvl_addr[1]),
        .leaf_fault   (leaf_fault),
        .leaf_need_wb (leaf_need_wb),
        .leaf_new     (leaf_new),
        .va_q         (va_q),
        .store_q      (store_q),
        .next_ppn_q   (next_ppn_q),
        .req_ready    (req_ready),
        .resp_valid   (resp_valid),
        .resp_fault   (resp_fault),
        .resp_paddr   (resp_paddr),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata)
    );

endmodule

// File: rtl/pgwalk_checker.sv
// Protocol and result checker for the walker, attached by bind.
// Captures the accepted virtual address itself so that it can check
// the offset of the response. Assumes the memory acknowledges only
// requests that are pending.
module pgwalk_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [ADDR_W-1:0] resp_paddr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata
);
    logic [OFF_W-1:0] off_cap;

    // Record the page offset of each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cap <= '0;
        end else if (req_valid && req_ready) begin
            off_cap <= req_vaddr[OFF_W-1:0];
        end
    end

    // R1: no memory traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    // R5: a fault carries no address
    p_fault_noaddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

    // R5: a successful response keeps the page offset of its request
    p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[OFF_W-1:0] == off_cap));

    // R6: every write-back has the referenced flag set
    p_wb_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[3]);

    // R9: the walker drops ready after acceptance
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: the response is a single-cycle pulse followed by idle
    p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R10: a pending memory access holds still until acknowledged
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind pgwalk_top pgwalk_checker #(
    .ADDR_W (32),
    .OFF_W  (12)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/pgwalk_top_bench.sv
`timescale 1ns/1ps
// Directed bench for the page table walker: a sparse memory model with
// programmable acknowledge latency, one task per scenario.
module pgwalk_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [19:0] base_wr_ppn = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic        resp_valid;
    logic        resp_fault;
    logic [31:0] resp_paddr;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk  = 0;
    int n_fail = 0;

    // Memory model state and traffic log
    logic [31:0] mem [logic [31:0]];
    int          lat      = 0;
    int          wait_cnt = 0;
    int          n_rd     = 0;
    int          n_wr     = 0;
    int          hold_err = 0;
    logic [31:0] rd_log0, rd_log1, wr_addr_log, wr_data_log;
    logic [31:0] h_addr, h_wdata;
    logic        h_we;

    always #10 clk = ~clk;

    pgwalk_top u_pgwalk_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_wr_en  (base_wr_en),
        .base_wr_ppn (base_wr_ppn),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_vaddr   (req_vaddr),
        .req_store   (req_store),
        .resp_valid  (resp_valid),
        .resp_fault  (resp_fault),
        .resp_paddr  (resp_paddr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata)
    );

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory responder: acknowledges on a falling edge after lat waits
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                h_addr = mem_addr; h_we = mem_we; h_wdata = mem_wdata;
            end else if (mem_addr !== h_addr || mem_we !== h_we || mem_wdata !== h_wdata) begin
                hold_err++;
            end
            if (wait_cnt >= lat) begin
                mem_ack  = 1'b1;
                wait_cnt = 0;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_addr_log   = mem_addr;
                    wr_data_log   = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = rd_word(mem_addr);
                    if (n_rd == 0) rd_log0 = mem_addr;
                    if (n_rd == 1) rd_log1 = mem_addr;
                    n_rd++;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic set_root(input logic [19:0] ppn);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_ppn = ppn;
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    // One walk: drive the request, wait for the response, check handshake
    task automatic walk(input logic [31:0] va, input logic st,
                        output logic flt, output logic [31:0] pa);
        int cyc = 0;
        int busy_ready = 0;
        @(negedge clk);
        n_rd = 0; n_wr = 0;
        req_valid = 1'b1; req_vaddr = va; req_store = st;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && cyc < 200) begin
            if (req_ready) busy_ready++;
            @(negedge clk);
            cyc++;
        end
        if (req_ready) busy_ready++;
        flt = resp_fault;
        pa  = resp_paddr;
        chk("R9 busy ready", busy_ready, 0);
        @(negedge clk);
        chk("R9 pulse", {31'b0, resp_valid}, 32'd0);
        chk("R9 idle again", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 resp", {31'b0, resp_valid}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_load_first;
        logic f; logic [31:0] p;
        lat = 0;
        walk(32'h0040_3ABC, 1'b0, f, p);
        chk("R2 dir addr", rd_log0, 32'h0001_0004);
        chk("R2 leaf addr", rd_log1, 32'h0002_000C);
        chk("R5 fault", {31'b0, f}, 32'd0);
        chk("R5 paddr", p, 32'h0055_5ABC);
        chk("R6 writes", n_wr, 1);
        chk("R6 ref set", wr_data_log, 32'h0055_500B);
        chk("R7 load keeps dirty", {31'b0, wr_data_log[4]}, 32'd0);
        chk("R6 wb addr", wr_addr_log, 32'h0002_000C);
    endtask

    task automatic t_store_first;
        logic f; logic [31:0] p;
        lat = 2;
        walk(32'h0040_4010, 1'b1, f, p);
        chk("R5 store paddr", p, 32'h0066_6010);
        chk("R7 dirty set", wr_data_log, 32'h0066_601F);
        chk("R7 writes", n_wr, 1);
    endtask

    task automatic t_writeback_filter;
        logic f; logic [31:0] p;
        lat = 1;
        walk(32'h0040_5000, 1'b0, f, p);
        chk("R8 load ref set paddr", p, 32'h0077_7000);
        chk("R8 load ref set writes", n_wr, 0);
        chk("R8 load ref set reads", n_rd, 2);
        walk(32'h0040_6004, 1'b1, f, p);
        chk("R8 store clean writes", n_wr, 1);
        chk("R8 store clean data", wr_data_log, 32'h0088_801F);
        walk(32'h0040_7008, 1'b1, f, p);
        chk("R8 store dirty writes", n_wr, 0);
        chk("R8 store dirty paddr", p, 32'h0099_9008);
        walk(32'h0040_3ABC, 1'b0, f, p);
        chk("R8 repeat load writes", n_wr, 0);
        chk("R8 repeat load paddr", p, 32'h0055_5ABC);
    endtask

    task automatic t_dir_invalid;
        logic f; logic [31:0] p;
        lat = 3;
        walk(32'h0080_0123, 1'b0, f, p);
        chk("R3 fault", {31'b0, f}, 32'd1);
        chk("R3 reads", n_rd, 1);
        chk("R3 dir addr", rd_log0, 32'h0001_0008);
        chk("R3 writes", n_wr, 0);
        chk("R5 fault paddr", p, 32'h0);
    endtask

    task automatic t_leaf_faults;
        logic f; logic [31:0] p;
        lat = 0;
        walk(32'h0040_8000, 1'b0, f, p);
        chk("R4 nonresident fault", {31'b0, f}, 32'd1);
        chk("R4 nonresident writes", n_wr, 0);
        chk("R4 nonresident reads", n_rd, 2);
        walk(32'h0040_9000, 1'b0, f, p);
        chk("R4 load unreadable fault", {31'b0, f}, 32'd1);
        chk("R4 load unreadable writes", n_wr, 0);
        walk(32'h0040_A000, 1'b1, f, p);
        chk("R4 store unwritable fault", {31'b0, f}, 32'd1);
        chk("R4 store unwritable paddr", p, 32'h0);
        chk("R4 store unwritable entry", rd_word(32'h0002_0028), 32'h00CC_C003);
    endtask

    task automatic t_root_switch;
        logic f; logic [31:0] p;
        lat = 1;
        set_root(20'h00030);
        walk(32'h0040_3ABC, 1'b0, f, p);
        chk("R11 dir addr", rd_log0, 32'h0003_0004);
        chk("R11 leaf addr", rd_log1, 32'h0004_000C);
        chk("R11 paddr", p, 32'h00DD_DABC);
        set_root(20'h00010);
        walk(32'h0040_3ABC, 1'b0, f, p);
        chk("R11 back paddr", p, 32'h0055_5ABC);
    endtask

    task automatic t_hold;
        chk("R10 hold errors", hold_err, 0);
    endtask

    initial begin
        #(20ns * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Tables: root at 0x10000, second level at 0x20000, alternate at 0x30000/0x40000
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0001_0008] = 32'h0000_0000;
        mem[32'h0002_000C] = 32'h0055_5003;
        mem[32'h0002_0010] = 32'h0066_6007;
        mem[32'h0002_0014] = 32'h0077_700B;
        mem[32'h0002_0018] = 32'h0088_800F;
        mem[32'h0002_001C] = 32'h0099_901F;
        mem[32'h0002_0020] = 32'h00AA_A006;
        mem[32'h0002_0024] = 32'h00BB_B005;
        mem[32'h0002_0028] = 32'h00CC_C003;
        mem[32'h0003_0004] = 32'h0004_0001;
        mem[32'h0004_000C] = 32'h00DD_D00B;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        set_root(20'h00010);
        t_load_first();
        t_store_first();
        t_writeback_filter();
        t_dir_invalid();
        t_leaf_faults();
        t_root_switch();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule